// File: doc/BRIEF.md
# Peripheral DMA Channel Pair

This block moves data between one serial peripheral and system memory without processor involvement. It holds two channels. The receive channel takes a character that the peripheral has ready and writes it to memory. The transmit channel reads a word from memory and hands it to the peripheral's holding register. Each channel is programmed with a 32-bit memory pointer and a 16-bit transfer count through a small configuration write port. That port stands in for the peripheral's own register space.

When the peripheral raises its request line, the channel issues a single bus cycle through a request/grant handshake. On the grant it advances the pointer by the transfer size (one or two bytes) and lowers the count by one. When the count reaches zero, the channel holds an end-of-transfer flag that the peripheral shows as a status bit. Each flag can be enabled onto a shared interrupt line. Only one bus cycle is in flight at a time, and receive wins when both channels ask in the same cycle.

Top module: `pdma_pair`

## Requirements
- R1: While rst_n is low, bus_req, rx_ack and tx_load are low. After reset both counts are zero, so rx_eot and tx_eot are high.
- R2: A channel whose count is zero ignores its peripheral request. No bus request is raised for it, and its end-of-transfer flag stays high.
- R3: A configuration write with cfg_sel = 0 loads the receive pointer, 1 loads the receive count, 2 loads the transmit pointer and 3 loads the transmit count (count from cfg_wdata[15:0]). Loading a nonzero count drops that channel's end-of-transfer flag and arms the channel.
- R4: bus_req stays high, with bus_addr, bus_write and bus_size unchanged, until a cycle with bus_gnt high. That cycle completes the transfer, and bus_req is low in the following cycle. At most one bus cycle is outstanding.
- R5: The address of each transfer is the channel's current pointer. After a granted transfer the pointer advances by 2 if the size was wide (bus_size = 1) and by 1 otherwise, wrapping modulo 2^32. The count drops by one.
- R6: A receive transfer is a write (bus_write = 1) carrying rx_data on bus_wdata. rx_ack pulses for one cycle in the cycle after the grant.
- R7: A transmit transfer is a read (bus_write = 0). tx_data takes bus_rdata from the grant cycle, and tx_load pulses for one cycle in the cycle after the grant.
- R8: When both channels are armed and request in the same cycle with the bus idle, the receive transfer is issued first.
- R9: A channel's end-of-transfer flag rises after its last counted transfer. irq is high when any flag is high with its enable input high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 rx pointer, 1 rx count, 2 tx pointer, 3 tx count |
| cfg_wdata | input | 32 | Configuration write data |
| rx_req | input | 1 | Peripheral has receive data ready |
| rx_wide | input | 1 | Receive transfer size, 1 = two bytes |
| rx_data | input | 16 | Receive data from the peripheral |
| rx_ack | output | 1 | Receive data taken |
| tx_req | input | 1 | Peripheral transmit holding register empty |
| tx_wide | input | 1 | Transmit transfer size, 1 = two bytes |
| tx_data | output | 16 | Data for the transmit holding register |
| tx_load | output | 1 | tx_data valid, load strobe |
| rx_ien | input | 1 | Receive end-of-transfer interrupt enable |
| tx_ien | input | 1 | Transmit end-of-transfer interrupt enable |
| rx_eot | output | 1 | Receive end-of-transfer status |
| tx_eot | output | 1 | Transmit end-of-transfer status |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Bus cycle request |
| bus_gnt | input | 1 | Bus grant, completes the cycle |
| bus_addr | output | 32 | Bus address |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_size | output | 1 | 1 = two-byte access, 0 = one byte |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with the grant |

## Verification
Receive-only runs with narrow transfers and changing grant latency show that the pointer advances by one per transfer. They also show that the request and its address stay put while the grant is withheld. A wide transmit run that starts two bytes below the top of the address space separates an increment of two from an increment of one, and it exercises the wrap to zero. Requests raised on both channels in the same cycle show the issue order. Requests raised while a count is zero show that nothing reaches the bus and that the status and interrupt lines follow the flags and their enables.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int NCH   = 2;
  localparam int CH_RX = 0;
  localparam int CH_TX = 1;

  typedef enum logic [1:0] {
    SEL_RX_PTR = 2'd0,
    SEL_RX_CNT = 2'd1,
    SEL_TX_PTR = 2'd2,
    SEL_TX_CNT = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pdma_chan.sv
// One channel: pointer and count registers, stepped by a completed transfer.
module pdma_chan #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ptr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] wval,
  input  logic          step,
  input  logic          step_wide,
  output logic [AW-1:0] ptr,
  output logic          armed
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] incr;

  always_comb begin
    incr  = '0;
    incr[1] = step_wide;
    incr[0] = ~step_wide;
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (ld_ptr)
      ptr_d = wval;
    else if (step)
      ptr_d = ptr_q + incr;
    if (ld_cnt)
      cnt_d = wval[CW-1:0];
    else if (step && (cnt_q != '0))
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign ptr   = ptr_q;
  assign armed = (cnt_q != '0);
endmodule

// File: rtl/pdma_arb.sv
// Single-owner bus sequencer: lowest channel index wins a free bus.
module pdma_arb #(
  parameter int NCH = 2,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] want,
  input  logic [NCH-1:0] wide,
  input  logic           gnt,
  output logic           act,
  output logic [SW-1:0]  sel,
  output logic           wsz,
  output logic [NCH-1:0] done
);
  logic          act_q, act_d;
  logic [SW-1:0] sel_q, sel_d;
  logic          wsz_q, wsz_d;
  logic [SW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (want[i]) pick = SW'(i);
  end

  always_comb begin
    act_d = act_q;
    sel_d = sel_q;
    wsz_d = wsz_q;
    if (act_q) begin
      if (gnt) act_d = 1'b0;
    end else if (|want) begin
      act_d = 1'b1;
      sel_d = pick;
      wsz_d = wide[pick];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sel_q <= '0;
      wsz_q <= 1'b0;
    end else begin
      act_q <= act_d;
      sel_q <= sel_d;
      wsz_q <= wsz_d;
    end
  end

  always_comb begin
    done = '0;
    done[sel_q] = act_q & gnt;
  end

  assign act = act_q;
  assign sel = sel_q;
  assign wsz = wsz_q;
endmodule

// File: rtl/pdma_pair.sv
module pdma_pair #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          rx_req,
  input  logic          rx_wide,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ack,
  input  logic          tx_req,
  input  logic          tx_wide,
  output logic [DW-1:0] tx_data,
  output logic          tx_load,
  input  logic          rx_ien,
  input  logic          tx_ien,
  output logic          rx_eot,
  output logic          tx_eot,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  import pdma_pkg::*;

  logic [NCH-1:0] peri_req, peri_wide, armed, want, done;
  logic [AW-1:0]  ptr_a [NCH];
  logic           act, wsz;
  logic           sel;

  assign peri_req  = {tx_req, rx_req};
  assign peri_wide = {tx_wide, rx_wide};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ld_p, ld_c;
    assign ld_p = cfg_we && (cfg_sel == 2'(2 * i));
    assign ld_c = cfg_we && (cfg_sel == 2'(2 * i + 1));
    pdma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_ptr   (ld_p),
      .ld_cnt   (ld_c),
      .wval     (cfg_wdata),
      .step     (done[i]),
      .step_wide(wsz),
      .ptr      (ptr_a[i]),
      .armed    (armed[i])
    );
    assign want[i] = peri_req[i] & armed[i];
  end

  pdma_arb #(.NCH(NCH)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .want (want),
    .wide (peri_wide),
    .gnt  (bus_gnt),
    .act  (act),
    .sel  (sel),
    .wsz  (wsz),
    .done (done)
  );

  assign bus_req   = act;
  assign bus_addr  = ptr_a[sel];
  assign bus_write = (sel == 1'(CH_RX));
  assign bus_size  = wsz;
  assign bus_wdata = rx_data;

  // peripheral-side strobes, one cycle after the grant
  logic          ack_q, ack_d, load_q, load_d;
  logic [DW-1:0] txd_q, txd_d;

  always_comb begin
    ack_d  = done[CH_RX];
    load_d = done[CH_TX];
    txd_d  = done[CH_TX] ? bus_rdata : txd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      load_q <= 1'b0;
      txd_q  <= '0;
    end else begin
      ack_q  <= ack_d;
      load_q <= load_d;
      txd_q  <= txd_d;
    end
  end

  assign rx_ack  = ack_q;
  assign tx_load = load_q;
  assign tx_data = txd_q;
  assign rx_eot  = ~armed[CH_RX];
  assign tx_eot  = ~armed[CH_TX];
  assign irq     = (rx_eot & rx_ien) | (tx_eot & tx_ien);
endmodule

// File: rtl/pdma_pair_chk.sv
module pdma_pair_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_ack,
  input logic          tx_load,
  input logic [DW-1:0] tx_data,
  input logic          rx_eot,
  input logic          tx_eot,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [AW-1:0] bus_addr,
  input logic          bus_write,
  input logic          bus_size,
  input logic [DW-1:0] bus_rdata
);
  always @(posedge clk) begin
    if (!rst_n)
      assert_reset_quiet_R1: assert (!bus_req && !rx_ack && !tx_load);
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_write) && $stable(bus_size)));

  assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> !bus_req);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && rx_eot && tx_eot) |=> !bus_req);

  assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_write) |=> (rx_ack && !tx_load));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !bus_write) |=> (tx_load && !rx_ack && tx_data == $past(bus_rdata)));

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |=> !rx_ack);
endmodule

bind pdma_pair pdma_pair_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ack(rx_ack), .tx_load(tx_load), .tx_data(tx_data),
  .rx_eot(rx_eot), .tx_eot(tx_eot), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size), .bus_rdata(bus_rdata)
);

// File: tb/sim_pdma_pair.sv
`timescale 1ns/1ps
module sim_pdma_pair;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        rx_req, rx_wide, tx_req, tx_wide, rx_ien, tx_ien;
  logic [15:0] rx_data, tx_data, bus_wdata, bus_rdata;
  logic        rx_ack, tx_load, rx_eot, tx_eot, irq;
  logic        bus_req, bus_gnt, bus_write, bus_size;
  logic [31:0] bus_addr;

  pdma_pair u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign bus_rdata = bus_addr[15:0] ^ 16'hC3A5;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic        sz;
    logic [15:0] data;
  } xfer_t;

  xfer_t       expq[$];
  int          checks = 0, errors = 0;
  logic [31:0] m_ptr [2];
  int          m_cnt [2];
  int          gnt_lat = 0, wait_left = 0;
  int          pend = 0;
  logic [15:0] pend_data;
  bit          finished = 0;

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // bus responder and scoreboard monitor
  always @(negedge clk) begin
    if (pend == 1) begin
      chk(rx_ack === 1'b1, "R6 rx_ack", 32'(rx_ack), 1);
    end else if (pend == 2) begin
      chk(tx_load === 1'b1, "R7 tx_load", 32'(tx_load), 1);
      chk(tx_data === pend_data, "R7 tx_data", 32'(tx_data), 32'(pend_data));
    end
    pend = 0;
    if (bus_gnt) begin
      bus_gnt = 1'b0;
    end else if (bus_req === 1'b1) begin
      if (wait_left > 0) wait_left--;
      else begin
        bus_gnt   = 1'b1;
        wait_left = gnt_lat;
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected bus cycle", bus_addr, 0);
        end else begin
          xfer_t e;
          e = expq.pop_front();
          chk(bus_write === e.wr, "R8 direction/order", 32'(bus_write), 32'(e.wr));
          chk(bus_addr === e.addr, "R5 address", bus_addr, e.addr);
          chk(bus_size === e.sz, "R5 size", 32'(bus_size), 32'(e.sz));
          if (e.wr) chk(bus_wdata === e.data, "R6 write data", 32'(bus_wdata), 32'(e.data));
          pend      = e.wr ? 1 : 2;
          pend_data = e.data;
        end
        if (bus_write) rx_req = 1'b0; else tx_req = 1'b0;
      end
    end
  end

  task automatic cfg(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s[0]) m_cnt[s[1]] = int'(d[15:0]);
    else      m_ptr[s[1]] = d;
  endtask

  function automatic void expect_one(int c, bit wide, logic [15:0] d);
    xfer_t e;
    e.wr   = (c == 0);
    e.addr = m_ptr[c];
    e.sz   = wide;
    e.data = (c == 0) ? d : (m_ptr[c][15:0] ^ 16'hC3A5);
    expq.push_back(e);
    m_ptr[c] = m_ptr[c] + (wide ? 32'd2 : 32'd1);
    m_cnt[c]--;
  endfunction

  task automatic serve(int c, bit wide, logic [15:0] d);
    @(negedge clk);
    if (m_cnt[c] == 0) begin
      if (c == 0) begin rx_wide = wide; rx_data = d; rx_req = 1'b1; end
      else        begin tx_wide = wide; tx_req = 1'b1; end
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(bus_req === 1'b0, "R2 zero count ignored", 32'(bus_req), 0);
      end
      rx_req = 1'b0; tx_req = 1'b0;
    end else begin
      expect_one(c, wide, d);
      if (c == 0) begin rx_wide = wide; rx_data = d; rx_req = 1'b1; end
      else        begin tx_wide = wide; tx_req = 1'b1; end
      while ((c == 0) ? rx_req : tx_req) @(negedge clk);
    end
  endtask

  task automatic drain();
    while (expq.size() != 0 || bus_req) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    rx_req = 1'b0; tx_req = 1'b0; rx_wide = 1'b0; tx_wide = 1'b0;
    rx_data = '0; rx_ien = 1'b0; tx_ien = 1'b0; bus_gnt = 1'b0;
    m_ptr[0] = '0; m_ptr[1] = '0; m_cnt[0] = 0; m_cnt[1] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_req === 1'b0, "R1 bus_req", 32'(bus_req), 0);
    chk(rx_ack === 1'b0 && tx_load === 1'b0, "R1 strobes", 32'({rx_ack, tx_load}), 0);
    chk(rx_eot === 1'b1 && tx_eot === 1'b1, "R1 eot", 32'({rx_eot, tx_eot}), 3);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: request with zero count
    serve(0, 1'b0, 16'h1111);
    chk(rx_eot === 1'b1, "R2 eot held", 32'(rx_eot), 1);

    // R3: arm receive
    cfg(2'd0, 32'h0000_1000);
    cfg(2'd1, 32'h0003_0003);
    chk(rx_eot === 1'b0, "R3 eot cleared", 32'(rx_eot), 0);
    chk(tx_eot === 1'b1, "R3 other channel untouched", 32'(tx_eot), 1);

    // R5/R6: narrow receive transfers, growing grant latency (R4 hold)
    serve(0, 1'b0, 16'hA001);
    gnt_lat = 2;
    serve(0, 1'b0, 16'hA002);
    chk(rx_eot === 1'b0, "R9 eot low mid-run", 32'(rx_eot), 0);
    serve(0, 1'b0, 16'hA003);
    drain();
    chk(rx_eot === 1'b1, "R9 eot after last", 32'(rx_eot), 1);
    chk(irq === 1'b0, "R9 irq disabled", 32'(irq), 0);
    rx_ien = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R9 irq enabled", 32'(irq), 1);
    serve(0, 1'b0, 16'hA004); // R2 exhausted count ignored

    // R7/R5: wide transmit across the top of the address space
    gnt_lat = 3;
    cfg(2'd2, 32'hFFFF_FFFE);
    cfg(2'd3, 32'd2);
    chk(tx_eot === 1'b0, "R3 tx eot cleared", 32'(tx_eot), 0);
    serve(1, 1'b1, 16'h0);
    serve(1, 1'b1, 16'h0);
    drain();
    chk(tx_eot === 1'b1, "R9 tx eot", 32'(tx_eot), 1);

    // R8: simultaneous requests
    gnt_lat = 0;
    rx_ien = 1'b0;
    cfg(2'd0, 32'h0000_3000);
    cfg(2'd1, 32'd1);
    cfg(2'd2, 32'h0000_4001);
    cfg(2'd3, 32'd1);
    tx_ien = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0, "R9 irq with flags low", 32'(irq), 0);
    expect_one(0, 1'b1, 16'h5EED);
    expect_one(1, 1'b0, 16'h0);
    rx_wide = 1'b1; rx_data = 16'h5EED; tx_wide = 1'b0;
    rx_req = 1'b1; tx_req = 1'b1;
    while (rx_req || tx_req) @(negedge clk);
    drain();
    chk(irq === 1'b1, "R9 irq tx flag", 32'(irq), 1);
    chk(rx_eot === 1'b1 && tx_eot === 1'b1, "R9 both done", 32'({rx_eot, tx_eot}), 3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule